// File: doc/BRIEF.md
# Multiply and Multiply-Accumulate Unit

This unit performs integer multiplication for a small processor datapath. A single opcode input, qualified by a valid strobe, selects one of five operations: a byte-by-byte unsigned multiply, a signed or unsigned halfword multiply with a 32-bit product, and a signed or unsigned multiply-accumulate into a 32-bit accumulator held inside the unit. Every accepted operation returns its result one clock later, split into a high and a low halfword, together with a result-valid pulse.

The accumulator persists between operations. It clears on reset, can be loaded through a synchronous write port and is always visible on a read port. A signed accumulate sign-extends the product and wraps to 32 bits. It raises an overflow flag when the signed sum leaves the 32-bit range. An unsigned accumulate wraps modulo 2^32 and raises a carry flag when the sum passes 2^32. A load of the accumulator takes precedence over an accumulate issued in the same cycle.

Top module: `mul_mac_unit`

## Requirements
- R1: After reset, outValid, outOverflow and outCarry are 0 and accRdData is 0.
- R2: Opcode 0 (byte multiply) multiplies opA[7:0] by opB[7:0] as unsigned values. The 16-bit product appears on outLo and outHi is 0. The upper bytes of the operands have no effect.
- R3: Opcode 1 (signed halfword multiply) treats opA and opB as two's-complement 16-bit values. The 32-bit product appears with bits 31:16 on outHi and bits 15:0 on outLo.
- R4: Opcode 2 (unsigned halfword multiply) returns the unsigned 32-bit product of opA and opB, split the same way as in R3.
- R5: Opcode 3 (signed accumulate) adds the signed product of opA and opB to the accumulator, truncated to 32 bits. The new accumulator value appears on outHi/outLo and on accRdData.
- R6: Opcode 4 (unsigned accumulate) adds the unsigned product to the accumulator modulo 2^32 and reports the new value as in R5.
- R7: outOverflow is 1 with a result only when a signed accumulate's addends share a sign and the sum's sign differs from it. It is 0 for every other operation.
- R8: outCarry is 1 with a result only when an unsigned accumulate's true sum is at least 2^32. It is 0 for every other operation.
- R9: An operation accepted at a rising edge gives outValid high for exactly the following cycle, with its result.
- R10: accWrEn high at a rising edge loads accWrData into the accumulator, visible on accRdData after that edge. Multiply opcodes 0 to 2 leave the accumulator unchanged.
- R11: When accWrEn and an accumulate opcode are valid in the same cycle, the load wins. The accumulate is discarded and produces no outValid.
- R12: Opcodes 5 to 7 are ignored: no outValid and no change to the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operation request strobe |
| inOp | input | 3 | Operation code (0 to 4 legal) |
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| accWrEn | input | 1 | Accumulator load strobe |
| accWrData | input | 32 | Accumulator load value |
| accRdData | output | 32 | Current accumulator value |
| outValid | output | 1 | Result valid pulse |
| outHi | output | 16 | Result bits 31:16 |
| outLo | output | 16 | Result bits 15:0 |
| outOverflow | output | 1 | Signed accumulate overflow |
| outCarry | output | 1 | Unsigned accumulate carry |

## Verification
The table drives operands at the edges of the number range: all-ones, the most negative halfword against itself and against the most positive, and byte operands whose upper bytes are non-zero. These patterns separate signed from unsigned sign extension and show whether the byte multiply masks its inputs. Chained accumulates start from a cleared accumulator and run up to and past 2^32, which separates a correct unsigned wrap and carry from a saturating or carry-less sum. Directed loads of the accumulator to the signed extremes, followed by accumulates of plus and minus one, trigger overflow in both directions. Further directed cases cover a load colliding with an accumulate and the unused opcodes.

// File: rtl/mm_pkg.sv
package mm_pkg;

  typedef enum logic [2:0] {
    OP_MUL8U  = 3'd0,
    OP_MUL16S = 3'd1,
    OP_MUL16U = 3'd2,
    OP_MACS   = 3'd3,
    OP_MACU   = 3'd4
  } mm_op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic fire;        // operation accepted this cycle
    logic selByte;     // byte operands, zero-extended
    logic signedMode;  // sign-extend halfword operands
    logic doAcc;       // add product into accumulator
  } mm_ctl_t;

endpackage

// File: rtl/mm_ctrl.sv
module mm_ctrl
  import mm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic [2:0]  inOp,
  input  logic        accWrEn,
  output mm_ctl_t     ctl
);

  logic legalOp;
  logic isAcc;

  always_comb begin
    legalOp = 1'b1;
    isAcc   = 1'b0;
    ctl     = '0;
    unique case (inOp)
      OP_MUL8U:  ctl.selByte = 1'b1;
      OP_MUL16S: ctl.signedMode = 1'b1;
      OP_MUL16U: ;
      OP_MACS: begin
        ctl.signedMode = 1'b1;
        isAcc = 1'b1;
      end
      OP_MACU:   isAcc = 1'b1;
      default:   legalOp = 1'b0;
    endcase
    ctl.doAcc = isAcc;
    // load port has priority over a colliding accumulate
    ctl.fire  = inValid && legalOp && !(isAcc && accWrEn);
  end

  // R12
  illegal_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inOp > 3'd4) |-> !ctl.fire);

  // R11
  load_collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accWrEn && ctl.doAcc) |-> !ctl.fire);

endmodule

// File: rtl/mm_datapath.sv
module mm_datapath
  import mm_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  mm_ctl_t              ctl,
  input  logic [HALF_W-1:0]    opA,
  input  logic [HALF_W-1:0]    opB,
  input  logic                 accWrEn,
  input  logic [2*HALF_W-1:0]  accWrData,
  output logic [2*HALF_W-1:0]  accRdData,
  output logic                 outValid,
  output logic [HALF_W-1:0]    outHi,
  output logic [HALF_W-1:0]    outLo,
  output logic                 outOverflow,
  output logic                 outCarry
);

  localparam int ACC_W = 2 * HALF_W;
  localparam int EXT_W = HALF_W + 1;
  localparam int PRD_W = 2 * EXT_W;

  logic [EXT_W-1:0]        extA, extB;
  logic signed [PRD_W-1:0] wideA, wideB, wideProd;
  logic [ACC_W-1:0]        product;
  logic [ACC_W:0]          rawSum;
  logic [ACC_W-1:0]        sumVal;
  logic                    sumOvf;
  logic [ACC_W-1:0]        accReg;

  // operand extension
  always_comb begin
    if (ctl.selByte) begin
      extA = EXT_W'(opA[BYTE_W-1:0]);
      extB = EXT_W'(opB[BYTE_W-1:0]);
    end else begin
      extA = {ctl.signedMode & opA[HALF_W-1], opA};
      extB = {ctl.signedMode & opB[HALF_W-1], opB};
    end
    wideA    = PRD_W'($signed(extA));
    wideB    = PRD_W'($signed(extB));
    wideProd = wideA * wideB;
    product  = wideProd[ACC_W-1:0];
  end

  // accumulation
  always_comb begin
    rawSum = {1'b0, accReg} + {1'b0, product};
    sumVal = rawSum[ACC_W-1:0];
    sumOvf = (accReg[ACC_W-1] == product[ACC_W-1]) &&
             (sumVal[ACC_W-1] != accReg[ACC_W-1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accReg <= '0;
    end else if (accWrEn) begin
      accReg <= accWrData;
    end else if (ctl.fire && ctl.doAcc) begin
      accReg <= sumVal;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid    <= 1'b0;
      outHi       <= '0;
      outLo       <= '0;
      outOverflow <= 1'b0;
      outCarry    <= 1'b0;
    end else begin
      outValid <= ctl.fire;
      if (ctl.fire) begin
        {outHi, outLo} <= ctl.doAcc ? sumVal : product;
        outOverflow    <= ctl.doAcc && ctl.signedMode && sumOvf;
        outCarry       <= ctl.doAcc && !ctl.signedMode && rawSum[ACC_W];
      end
    end
  end

  assign accRdData = accReg;

  // R8
  carry_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.fire && ctl.doAcc && !ctl.signedMode) |=>
      (outCarry == (accReg < $past(accReg))));

  // R7
  overflow_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outOverflow) |-> (accReg[ACC_W-1] != $past(accReg[ACC_W-1])));

  // R10
  acc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accWrEn |=> (accReg == $past(accWrData)));

  // R10
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!accWrEn && !(ctl.fire && ctl.doAcc)) |=> $stable(accReg));

  // R7
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> !(outOverflow && outCarry));

endmodule

// File: rtl/mul_mac_unit.sv
module mul_mac_unit
  import mm_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 inValid,
  input  logic [2:0]           inOp,
  input  logic [HALF_W-1:0]    opA,
  input  logic [HALF_W-1:0]    opB,
  input  logic                 accWrEn,
  input  logic [2*HALF_W-1:0]  accWrData,
  output logic [2*HALF_W-1:0]  accRdData,
  output logic                 outValid,
  output logic [HALF_W-1:0]    outHi,
  output logic [HALF_W-1:0]    outLo,
  output logic                 outOverflow,
  output logic                 outCarry
);

  mm_ctl_t ctl;

  mm_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .inValid (inValid),
    .inOp    (inOp),
    .accWrEn (accWrEn),
    .ctl     (ctl)
  );

  mm_datapath #(.HALF_W(HALF_W), .BYTE_W(BYTE_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl         (ctl),
    .opA         (opA),
    .opB         (opB),
    .accWrEn     (accWrEn),
    .accWrData   (accWrData),
    .accRdData   (accRdData),
    .outValid    (outValid),
    .outHi       (outHi),
    .outLo       (outLo),
    .outOverflow (outOverflow),
    .outCarry    (outCarry)
  );

endmodule

// File: tb/mul_mac_unit_test.sv
`timescale 1ns/1ps
module mul_mac_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  inOp = '0;
  logic [15:0] opA = '0, opB = '0;
  logic        accWrEn = 1'b0;
  logic [31:0] accWrData = '0;
  logic [31:0] accRdData;
  logic        outValid;
  logic [15:0] outHi, outLo;
  logic        outOverflow, outCarry;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] accModel = '0;
  bit doneFlag = 0;

  always #2.5 clk = ~clk;

  mul_mac_unit uut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inOp(inOp),
    .opA(opA), .opB(opB), .accWrEn(accWrEn), .accWrData(accWrData),
    .accRdData(accRdData), .outValid(outValid), .outHi(outHi),
    .outLo(outLo), .outOverflow(outOverflow), .outCarry(outCarry)
  );

  // {op, a, b}
  localparam int NV = 12;
  localparam logic [34:0] VEC [0:NV-1] = '{
    {3'd0, 16'h00FF, 16'h00FF},
    {3'd0, 16'hAB12, 16'hCD34},
    {3'd1, 16'hFFFF, 16'hFFFF},
    {3'd1, 16'h8000, 16'h8000},
    {3'd1, 16'h8000, 16'h7FFF},
    {3'd2, 16'hFFFF, 16'hFFFF},
    {3'd2, 16'h1234, 16'h0010},
    {3'd4, 16'hFFFF, 16'hFFFF},
    {3'd4, 16'hFFFF, 16'h0002},
    {3'd4, 16'h0001, 16'h0001},
    {3'd3, 16'hFFFF, 16'h0003},
    {3'd3, 16'h0100, 16'h0100}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b,
                       output logic [31:0] res, output logic ov, output logic cy);
    int sa, sb;
    longint ua, ub, s, u;
    logic [31:0] prod;
    sa = $signed(a); sb = $signed(b);
    ua = longint'(a); ub = longint'(b);
    ov = 0; cy = 0;
    case (op)
      3'd0: res = 32'(a[7:0]) * 32'(b[7:0]);
      3'd1: res = 32'(sa * sb);
      3'd2: res = 32'(ua * ub);
      3'd3: begin
        prod = 32'(sa * sb);
        s = longint'($signed(accModel)) + longint'($signed(prod));
        res = s[31:0];
        ov = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        accModel = res;
      end
      default: begin
        u = longint'(accModel) + ua * ub;
        res = u[31:0];
        cy = (u >= 64'h1_0000_0000);
        accModel = res;
      end
    endcase
  endtask

  task automatic apply(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b);
    logic [31:0] er;
    logic eo, ec;
    string tag;
    model(op, a, b, er, eo, ec);
    case (op)
      3'd0: tag = "R2";
      3'd1: tag = "R3";
      3'd2: tag = "R4";
      3'd3: tag = "R5";
      default: tag = "R6";
    endcase
    @(negedge clk);
    inOp = op; opA = a; opB = b; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check("R9 valid", 64'(outValid), 64'd1);
    check(tag, 64'({outHi, outLo}), 64'(er));
    check("R7 overflow", 64'(outOverflow), 64'(eo));
    check("R8 carry", 64'(outCarry), 64'(ec));
    check("R10 acc", 64'(accRdData), 64'(accModel));
    @(negedge clk);
    check("R9 pulse", 64'(outValid), 64'd0);
  endtask

  task automatic loadAcc(input logic [31:0] v);
    @(negedge clk);
    accWrEn = 1'b1; accWrData = v;
    @(negedge clk);
    accWrEn = 1'b0;
    accModel = v;
    check("R10 load", 64'(accRdData), 64'(v));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", 64'(outValid), 64'd0);
    check("R1 acc", 64'(accRdData), 64'd0);
    check("R1 flags", 64'({outOverflow, outCarry}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++)
      apply(VEC[i][34:32], VEC[i][31:16], VEC[i][15:0]);

    // R7 positive overflow
    loadAcc(32'h7FFF_FFFF);
    apply(3'd3, 16'h0001, 16'h0001);
    // R7 negative overflow
    loadAcc(32'h8000_0000);
    apply(3'd3, 16'hFFFF, 16'h0001);
    // R8 carry from a large accumulator
    loadAcc(32'hFFFF_0000);
    apply(3'd4, 16'h0100, 16'h0100);

    // R11 load collides with accumulate
    @(negedge clk);
    accWrEn = 1'b1; accWrData = 32'h1234_5678;
    inValid = 1'b1; inOp = 3'd4; opA = 16'h0010; opB = 16'h0010;
    @(negedge clk);
    accWrEn = 1'b0; inValid = 1'b0;
    accModel = 32'h1234_5678;
    check("R11 no result", 64'(outValid), 64'd0);
    check("R11 acc", 64'(accRdData), 64'h1234_5678);

    // R12 unused opcodes
    for (int k = 5; k < 8; k++) begin
      @(negedge clk);
      inValid = 1'b1; inOp = 3'(k); opA = 16'h0003; opB = 16'h0005;
      @(negedge clk);
      inValid = 1'b0;
      check("R12 no result", 64'(outValid), 64'd0);
      check("R12 acc", 64'(accRdData), 64'(accModel));
    end

    // R10 multiply with concurrent load: load taken, multiply still runs
    @(negedge clk);
    accWrEn = 1'b1; accWrData = 32'h0000_0042;
    inValid = 1'b1; inOp = 3'd2; opA = 16'h0007; opB = 16'h0006;
    @(negedge clk);
    accWrEn = 1'b0; inValid = 1'b0;
    check("R10 mul with load", 64'({outValid, outHi, outLo}), {31'd0, 1'b1, 32'd42});
    check("R10 acc loaded", 64'(accRdData), 64'h42);

    doneFlag = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!doneFlag) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule